// File: doc/BRIEF.md
# Ordered Dial Combination Lock

This block is a synchronous state machine that guards a lock worked by a dial. Each dial operation is a turn direction together with a number from 0 to 31. It arrives as a single-cycle pulse on `op_valid`. The block follows how far the user has got through a fixed series of three operations. It raises `lock_open` only after the whole series has arrived in the right order. Only the order counts, so the same three numbers given in any other order, or with the wrong turn direction, leave the lock shut.

The operation input is a strobe with no back-pressure. There is no ready signal, and every pulse on `op_valid` is taken in the cycle it appears. A source that cannot hold an operation for later must present it exactly once. `relock` is a plain control pin. While the lock is open, it shuts the lock again. The three steps of the series are parameters. By default the series is right-13, then left-22, then right-3.

Top module: `dial_seq_lock`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters the idle state after that edge, with `state_code` = 2'b00 and `lock_open` = 0.
- R2: `state_code` encodes idle as 00, one step done as 01, two steps done as 10 and open as 11. `lock_open` is 1 exactly when `state_code` is 11.
- R3: `op_dir` = 1 means right and `op_dir` = 0 means left. From idle, a valid right-13, then left-22, then right-3 moves the state to 01, then 10, then 11. Each change is seen after the clock edge at which `op_valid` was sampled high.
- R4: In a cycle with `op_valid` low and no effective relock, the state is unchanged.
- R5: In states 00, 01 and 10, a valid operation that is not the expected next step sends the state to 00. The exception is a wrong operation equal to the first step (right-13), which sends the state to 01.
- R6: The three values given in a different order, or with a wrong direction, never reach state 11. For example, right-3 then left-22 then right-13 ends in 01, and left-13 from idle ends in 00.
- R7: In state 11, valid operations without `relock` leave the state at 11.
- R8: In state 11, `relock` high sends the state to 00 at the next edge. This also holds when a valid operation arrives in the same cycle.
- R9: Outside state 11, `relock` has no effect. The state follows only the operation rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | One-cycle strobe marking a dial operation |
| op_dir | input | 1 | Turn direction, 1 = right, 0 = left |
| op_val | input | 5 | Dial number 0..31 |
| relock | input | 1 | Request to shut the open lock |
| lock_open | output | 1 | High while the lock is open |
| state_code | output | 2 | Current progress state code |

## Verification
Two functions can fall in the same cycle. One is a relock request. The other is a dial operation that would otherwise be ignored in the open state, or that would advance the state elsewhere. The bench opens the lock and then pulses `relock` together with a valid operation, including the first-step value, and expects state 00 rather than 01 or 11. It also pulses `relock` together with correct steps while closed, and expects the series to advance as if `relock` were low.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int NUM_STEPS = 3;
  localparam int STATE_W   = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 2'b00,
    ST_ONE   = 2'b01,
    ST_TWO   = 2'b10,
    ST_OPEN  = 2'b11
  } lock_state_t;
endpackage

// File: rtl/lock_step_cmp.sv
module lock_step_cmp #(
  parameter int VAL_W = 5,
  parameter logic [VAL_W-1:0] REF_VAL = '0,
  parameter logic REF_DIR = 1'b1
) (
  input  logic             dir_i,
  input  logic [VAL_W-1:0] val_i,
  output logic             hit_o
);
  always_comb hit_o = (dir_i == REF_DIR) && (val_i == REF_VAL);
endmodule

// File: rtl/lock_next.sv
module lock_next
  import lock_pkg::*;
#(
  parameter int NS = NUM_STEPS
) (
  input  lock_state_t    cur_i,
  input  logic           valid_i,
  input  logic           relock_i,
  input  logic [NS-1:0]  hit_i,
  output lock_state_t    nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (cur_i == ST_OPEN) begin
      if (relock_i) nxt_o = ST_IDLE;
    end else if (valid_i) begin
      if (hit_i[cur_i])      nxt_o = lock_state_t'(cur_i + 2'd1);
      else if (hit_i[0])     nxt_o = ST_ONE;
      else                   nxt_o = ST_IDLE;
    end
  end
endmodule

// File: rtl/dial_seq_lock.sv
module dial_seq_lock
  import lock_pkg::*;
#(
  parameter int VAL_W = 5,
  parameter logic [VAL_W-1:0] S1_VAL = 5'd13,
  parameter logic             S1_DIR = 1'b1,
  parameter logic [VAL_W-1:0] S2_VAL = 5'd22,
  parameter logic             S2_DIR = 1'b0,
  parameter logic [VAL_W-1:0] S3_VAL = 5'd3,
  parameter logic             S3_DIR = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic             op_dir,
  input  logic [VAL_W-1:0] op_val,
  input  logic             relock,
  output logic             lock_open,
  output logic [STATE_W-1:0] state_code
);
  localparam logic [NUM_STEPS*VAL_W-1:0] STEP_VALS = {S3_VAL, S2_VAL, S1_VAL};
  localparam logic [NUM_STEPS-1:0]       STEP_DIRS = {S3_DIR, S2_DIR, S1_DIR};

  logic [NUM_STEPS-1:0] hit;
  lock_state_t state_q, state_d;

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_step
    lock_step_cmp #(
      .VAL_W  (VAL_W),
      .REF_VAL(STEP_VALS[g*VAL_W +: VAL_W]),
      .REF_DIR(STEP_DIRS[g])
    ) i_cmp (
      .dir_i(op_dir),
      .val_i(op_val),
      .hit_o(hit[g])
    );
  end

  lock_next #(.NS(NUM_STEPS)) i_next (
    .cur_i   (state_q),
    .valid_i (op_valid),
    .relock_i(relock),
    .hit_i   (hit),
    .nxt_o   (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign state_code = state_q;
  assign lock_open  = (state_q == ST_OPEN);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (state_code == 2'b00 && !lock_open));

  assert_open_after_op_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_open) |-> $past(op_valid));

  assert_hold_no_op_R4: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !(relock && lock_open)) |=> $stable(state_code));

  assert_idle_moves_R5: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b00) |=> (state_code <= 2'b01));

  assert_open_ignores_op_R7: assert property (@(posedge clk) disable iff (rst)
    (lock_open && !relock) |=> lock_open);

  assert_relock_R8: assert property (@(posedge clk) disable iff (rst)
    (lock_open && relock) |=> (state_code == 2'b00));
endmodule

// File: tb/test_dial_seq_lock.sv
module test_dial_seq_lock;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic op_dir = 1'b0;
  logic [4:0] op_val = '0;
  logic relock = 1'b0;
  logic lock_open;
  logic [1:0] state_code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dial_seq_lock i_dial_seq_lock (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_dir(op_dir),
    .op_val(op_val), .relock(relock), .lock_open(lock_open),
    .state_code(state_code)
  );

  task automatic chk(input string tag, input logic [1:0] exp_st);
    total++;
    if (state_code !== exp_st || lock_open !== (exp_st == 2'b11)) begin
      bad++;
      $display("FAIL %s: state=%b open=%b expected state=%b open=%b",
               tag, state_code, lock_open, exp_st, exp_st == 2'b11);
    end
  endtask

  // drive one cycle at a falling edge, sample at the next falling edge
  task automatic step(input logic v, input logic d, input logic [4:0] n, input logic rl);
    @(negedge clk);
    op_valid = v; op_dir = d; op_val = n; relock = rl;
    @(negedge clk);
    op_valid = 0; relock = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
  endtask

  task automatic t_reset();
    step(1, 1, 13, 0);
    do_reset();
    chk("R1 reset to idle", 2'b00);
  endtask

  task automatic t_open_seq();
    do_reset();
    step(1, 1, 13, 0); chk("R3 step one", 2'b01);
    step(1, 0, 22, 0); chk("R3 step two", 2'b10);
    step(1, 1, 3, 0);  chk("R2 R3 open", 2'b11);
  endtask

  task automatic t_idle_hold();
    do_reset();
    step(1, 1, 13, 0);
    step(0, 0, 22, 0); chk("R4 no strobe holds", 2'b01);
    step(0, 1, 3, 0);  chk("R4 still held", 2'b01);
  endtask

  task automatic t_wrong();
    do_reset();
    step(1, 1, 13, 0); step(1, 0, 5, 0); chk("R5 wrong in B", 2'b00);
    step(1, 1, 13, 0); step(1, 0, 22, 0); step(1, 1, 13, 0);
    chk("R5 first step in C", 2'b01);
    step(1, 1, 13, 0); chk("R5 first step in B", 2'b01);
    step(1, 0, 22, 0); step(1, 1, 4, 0); chk("R5 wrong in C", 2'b00);
  endtask

  task automatic t_order();
    do_reset();
    step(1, 1, 3, 0); step(1, 0, 22, 0); step(1, 1, 13, 0);
    chk("R6 reversed order", 2'b01);
    do_reset();
    step(1, 0, 13, 0); chk("R6 wrong direction", 2'b00);
    step(1, 1, 13, 0); step(1, 1, 22, 0); step(1, 1, 3, 0);
    chk("R6 right-22 not accepted", 2'b00);
  endtask

  task automatic t_open_ignore();
    t_open_seq();
    step(1, 1, 13, 0); chk("R7 op ignored in open", 2'b11);
    step(1, 0, 7, 0);  chk("R7 wrong op ignored", 2'b11);
  endtask

  task automatic t_relock();
    t_open_seq();
    step(0, 0, 0, 1); chk("R8 relock", 2'b00);
    step(1, 1, 13, 0); step(1, 0, 22, 0); step(1, 1, 3, 0);
    step(1, 1, 13, 1); chk("R8 relock with op", 2'b00);
  endtask

  task automatic t_relock_closed();
    do_reset();
    step(0, 0, 0, 1);  chk("R9 relock idle", 2'b00);
    step(1, 1, 13, 1); chk("R9 relock with step one", 2'b01);
    step(1, 0, 22, 1); chk("R9 relock with step two", 2'b10);
    step(0, 0, 0, 1);  chk("R9 relock alone in C", 2'b10);
  endtask

  initial begin
    do_reset();
    chk("R1 initial", 2'b00);
    t_reset();
    t_open_seq();
    t_idle_hold();
    t_wrong();
    t_order();
    t_open_ignore();
    t_relock();
    t_relock_closed();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule